// File: doc/BRIEF.md
# USB Suspend and Resume Controller

This block sits beside the serial interface engine of a full-speed USB device. It watches the decoded bus line state and measures how long the bus has been idle, using a slow time-base pulse. When the idle period runs past a programmable limit, it raises a suspend interrupt flag. Firmware then puts the device to sleep by setting and then clearing a go-suspend control bit. The falling edge of that bit is what moves the block into the suspended state.

While suspended, the block holds its suspend output high. It blocks every register write request and every FIFO write request. Optionally, it runs a divided slow clock for low-power logic. Wake-up can come from the host, as a K state on the bus, or from the local application, as the wake pin. A host wake-up can be qualified by bus-voltage presence. Each wake-up sets a resume interrupt flag. The write lock is not released by the wake-up itself. It lasts until firmware issues a dedicated unlock command.

Top module: `usb_susp_ctrl`

## Requirements
- R1: The line state is encoded 2'b00 = SE0, 2'b01 = J (idle), 2'b10 = K, 2'b11 = SE1. `idle_long` goes high once more than TICKS_PER_MS*IDLE_MS `tick` pulses have been seen while the line stayed J without interruption. Any non-J line state clears the count and `idle_long` on the next clock.
- R2: `susp_irq` is set in the cycle after the tick that first carries the idle count past the limit. It is set only once per unbroken idle period. It is cleared by `int_rd`, and a set in the same cycle wins over the clear.
- R3: A high-to-low transition of `go_susp` while not suspended raises `suspend_o` on the next clock. A rising edge of `go_susp`, or a steady level, never enters suspend.
- R4: While `suspend_o` is high, `reg_wr_en` and `fifo_wr_en` are low whatever the write requests are.
- R5: While suspended, a K line state wakes the block: `suspend_o` falls on the next clock.
- R6: While suspended, `wakeup_pin` high wakes the block on the next clock, independent of bus-voltage sensing.
- R7: When `vbus_sense_en` is high and `vbus_present` is low, a K line state while suspended has no effect, and `suspend_o` stays high.
- R8: Every wake-up sets `resume_irq` on the same clock on which `suspend_o` falls. `int_rd` clears it, and a set in the same cycle wins over the clear.
- R9: Write access stays blocked after resume until `unlock_cmd` is seen while not suspended. An `unlock_cmd` during suspend is ignored. Once unlocked, `reg_wr_en` follows `wr_req_reg` and `fifo_wr_en` follows `wr_req_fifo`.
- R10: While suspended with `lazy_en` high, `lazy_clk` toggles once every LAZY_HALF clocks. At all other times it returns low on the next clock.
- R11: After reset, the block is not suspended and not locked, both flags are clear, `idle_long` is low and `lazy_clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base pulse, TICKS_PER_MS per millisecond |
| line_state | input | 2 | Decoded bus line state |
| vbus_sense_en | input | 1 | Qualify host wake-up with bus voltage |
| vbus_present | input | 1 | Bus voltage detected |
| go_susp | input | 1 | Firmware go-suspend control bit |
| wakeup_pin | input | 1 | Application wake-up request |
| unlock_cmd | input | 1 | Unlock command strobe |
| lazy_en | input | 1 | Enable slow clock while suspended |
| int_rd | input | 1 | Interrupt read strobe, clears flags |
| wr_req_reg | input | 1 | Register write request |
| wr_req_fifo | input | 1 | FIFO write request |
| suspend_o | output | 1 | Device suspended |
| idle_long | output | 1 | Bus idle beyond the limit |
| susp_irq | output | 1 | Suspend interrupt flag |
| resume_irq | output | 1 | Resume interrupt flag |
| reg_wr_en | output | 1 | Gated register write enable |
| fifo_wr_en | output | 1 | Gated FIFO write enable |
| lazy_clk | output | 1 | Divided slow clock |

## Verification
The bench builds the block with TICKS_PER_MS=4, IDLE_MS=3 and LAZY_HALF=3, and drives a tick on every other clock. With these values the idle limit is crossed after about 26 clocks, so idle detection, its re-arm after a K state and the flag clear race all fit in a short run. The short divider lets several slow-clock toggles, and the return to low on wake-up, be compared edge by edge. A behavioural model tracks the count, the suspend and lock state and both flags. The bench compares every output with that model on every clock through suspend entry, gated and ungated host wake, pin wake and unlock ordering.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  function automatic int unsigned idle_limit(input int unsigned tpm,
                                             input int unsigned ms);
    return tpm * ms;
  endfunction

  function automatic logic is_idle(input logic [1:0] ls);
    return ls == LS_J;
  endfunction

  function automatic logic host_wake_ok(input logic [1:0] ls,
                                        input logic sense_en,
                                        input logic vbus);
    return (ls == LS_K) && !(sense_en && !vbus);
  endfunction

endpackage

// File: rtl/usb_susp_idle_timer.sv
module usb_susp_idle_timer #(
  parameter int unsigned LIMIT = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_idle,
  output logic idle_long,
  output logic idle_evt
);
  localparam int unsigned CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign idle_evt  = line_idle && tick && (cnt_q == LIM);
  assign idle_long = cnt_q > LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!line_idle) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q <= LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/usb_susp_state.sv
module usb_susp_state (
  input  logic clk,
  input  logic rst_n,
  input  logic go_susp,
  input  logic wake_host,
  input  logic wake_pin,
  input  logic unlock_cmd,
  output logic susp_q,
  output logic lock_q,
  output logic go_fall,
  output logic wake_evt
);
  logic go_q;
  logic enter_evt;

  assign go_fall   = go_q && !go_susp;
  assign wake_evt  = susp_q && (wake_host || wake_pin);
  assign enter_evt = go_fall && !susp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q <= 1'b0;
    end else begin
      go_q <= go_susp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q <= 1'b0;
    end else if (wake_evt) begin
      susp_q <= 1'b0;
    end else if (enter_evt) begin
      susp_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (enter_evt) begin
      lock_q <= 1'b1;
    end else if (!susp_q && unlock_cmd) begin
      lock_q <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_susp_flag.sv
module usb_susp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (set) begin
      q <= 1'b1;
    end else if (clr) begin
      q <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_susp_lazy_div.sv
module usb_susp_lazy_div #(
  parameter int unsigned HALF = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic lazy_clk
);
  localparam int unsigned DW = $clog2(HALF + 1);
  localparam logic [DW-1:0] LAST = DW'(HALF - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      lazy_clk <= 1'b0;
    end else if (!active) begin
      div_q    <= '0;
      lazy_clk <= 1'b0;
    end else if (div_q == LAST) begin
      div_q    <= '0;
      lazy_clk <= !lazy_clk;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/usb_susp_ctrl.sv
module usb_susp_ctrl #(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned IDLE_MS      = 3,
  parameter int unsigned LAZY_HALF    = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] line_state,
  input  logic       vbus_sense_en,
  input  logic       vbus_present,
  input  logic       go_susp,
  input  logic       wakeup_pin,
  input  logic       unlock_cmd,
  input  logic       lazy_en,
  input  logic       int_rd,
  input  logic       wr_req_reg,
  input  logic       wr_req_fifo,
  output logic       suspend_o,
  output logic       idle_long,
  output logic       susp_irq,
  output logic       resume_irq,
  output logic       reg_wr_en,
  output logic       fifo_wr_en,
  output logic       lazy_clk
);
  import usb_susp_pkg::*;

  localparam int unsigned IDLE_TICKS = idle_limit(TICKS_PER_MS, IDLE_MS);
  localparam int unsigned NFLAG = 2;

  logic idle_evt;
  logic wake_host;
  logic go_fall;
  logic wake_evt;
  logic lock_q;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_q;

  assign wake_host = host_wake_ok(line_state, vbus_sense_en, vbus_present);

  usb_susp_idle_timer #(.LIMIT(IDLE_TICKS)) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .line_idle (is_idle(line_state)),
    .idle_long (idle_long),
    .idle_evt  (idle_evt)
  );

  usb_susp_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_susp    (go_susp),
    .wake_host  (wake_host),
    .wake_pin   (wakeup_pin),
    .unlock_cmd (unlock_cmd),
    .susp_q     (suspend_o),
    .lock_q     (lock_q),
    .go_fall    (go_fall),
    .wake_evt   (wake_evt)
  );

  assign flag_set = {wake_evt, idle_evt};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    usb_susp_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set[g]),
      .clr   (int_rd),
      .q     (flag_q[g])
    );
  end

  assign susp_irq   = flag_q[0];
  assign resume_irq = flag_q[1];

  assign reg_wr_en  = wr_req_reg  && !lock_q;
  assign fifo_wr_en = wr_req_fifo && !lock_q;

  usb_susp_lazy_div #(.HALF(LAZY_HALF)) u_lazy (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (suspend_o && lazy_en),
    .lazy_clk (lazy_clk)
  );
endmodule

// File: rtl/usb_susp_ctrl_chk.sv
module usb_susp_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic suspend_o,
  input logic lock_q,
  input logic go_fall,
  input logic wake_evt,
  input logic idle_evt,
  input logic wakeup_pin,
  input logic vbus_sense_en,
  input logic vbus_present,
  input logic unlock_cmd,
  input logic reg_wr_en,
  input logic fifo_wr_en,
  input logic lazy_clk,
  input logic susp_irq,
  input logic resume_irq
);
  assert_idle_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |=> susp_irq);

  assert_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_fall && !suspend_o) |=> suspend_o);

  assert_wr_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_o |-> (!reg_wr_en && !fifo_wr_en));

  assert_pin_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_o && wakeup_pin) |=> !suspend_o);

  assert_vbus_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_o && !wakeup_pin && vbus_sense_en && !vbus_present) |=> suspend_o);

  assert_resume_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (resume_irq && !suspend_o));

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !suspend_o && !unlock_cmd) |=> lock_q);

  assert_susp_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_o |-> lock_q);

  assert_lazy_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !suspend_o |=> !lazy_clk);
endmodule

bind usb_susp_ctrl usb_susp_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .suspend_o     (suspend_o),
  .lock_q        (lock_q),
  .go_fall       (go_fall),
  .wake_evt      (wake_evt),
  .idle_evt      (idle_evt),
  .wakeup_pin    (wakeup_pin),
  .vbus_sense_en (vbus_sense_en),
  .vbus_present  (vbus_present),
  .unlock_cmd    (unlock_cmd),
  .reg_wr_en     (reg_wr_en),
  .fifo_wr_en    (fifo_wr_en),
  .lazy_clk      (lazy_clk),
  .susp_irq      (susp_irq),
  .resume_irq    (resume_irq)
);

// File: tb/usb_susp_ctrl_tb.sv
`timescale 1ns/1ps
module usb_susp_ctrl_tb;
  localparam int TPM  = 4;
  localparam int IMS  = 3;
  localparam int HALF = 3;
  localparam int LIM  = TPM * IMS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic tick_run = 1'b0;
  logic [1:0] line_state = 2'b00;
  logic vbus_sense_en = 1'b0, vbus_present = 1'b1;
  logic go_susp = 1'b0, wakeup_pin = 1'b0, unlock_cmd = 1'b0;
  logic lazy_en = 1'b0, int_rd = 1'b0, wr_req_reg = 1'b1, wr_req_fifo = 1'b1;
  logic suspend_o, idle_long, susp_irq, resume_irq, reg_wr_en, fifo_wr_en, lazy_clk;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  usb_susp_ctrl #(.TICKS_PER_MS(TPM), .IDLE_MS(IMS), .LAZY_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_state(line_state),
    .vbus_sense_en(vbus_sense_en), .vbus_present(vbus_present),
    .go_susp(go_susp), .wakeup_pin(wakeup_pin), .unlock_cmd(unlock_cmd),
    .lazy_en(lazy_en), .int_rd(int_rd), .wr_req_reg(wr_req_reg),
    .wr_req_fifo(wr_req_fifo), .suspend_o(suspend_o), .idle_long(idle_long),
    .susp_irq(susp_irq), .resume_irq(resume_irq), .reg_wr_en(reg_wr_en),
    .fifo_wr_en(fifo_wr_en), .lazy_clk(lazy_clk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_cnt = 0, m_div = 0;
  bit  m_susp = 0, m_lock = 0, m_sf = 0, m_rf = 0, m_lz = 0, m_go = 0;
  bit  cmp_en = 0;

  always @(posedge clk) begin
    bit idle_ev, wake, fall, old_s;
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_susp = 0; m_lock = 0;
      m_sf = 0; m_rf = 0; m_lz = 0; m_go = 0;
    end else begin
      old_s   = m_susp;
      idle_ev = (line_state == 2'b01) && tick && (m_cnt == LIM);
      if (line_state != 2'b01) m_cnt = 0;
      else if (tick && m_cnt <= LIM) m_cnt++;
      wake = old_s && (wakeup_pin ||
             (line_state == 2'b10 && (!vbus_sense_en || vbus_present)));
      fall = m_go && !go_susp;
      if (old_s && lazy_en) begin
        if (m_div == HALF - 1) begin m_div = 0; m_lz = !m_lz; end
        else m_div++;
      end else begin
        m_div = 0; m_lz = 0;
      end
      if (wake) m_susp = 0;
      else if (fall && !old_s) begin m_susp = 1; m_lock = 1; end
      else if (!old_s && unlock_cmd) m_lock = 0;
      if (idle_ev) m_sf = 1; else if (int_rd) m_sf = 0;
      if (wake) m_rf = 1; else if (int_rd) m_rf = 0;
      m_go = go_susp;
    end
    #2;
    if (cmp_en) begin
      chk(idle_long == (m_cnt > LIM), "R1 idle_long", idle_long, m_cnt > LIM);
      chk(susp_irq == m_sf, "R2 susp_irq", susp_irq, m_sf);
      chk(suspend_o == m_susp, "R3/R5/R6/R7 suspend_o", suspend_o, m_susp);
      chk(reg_wr_en == (wr_req_reg && !m_lock), "R4/R9 reg_wr_en", reg_wr_en,
          wr_req_reg && !m_lock);
      chk(fifo_wr_en == (wr_req_fifo && !m_lock), "R4/R9 fifo_wr_en", fifo_wr_en,
          wr_req_fifo && !m_lock);
      chk(resume_irq == m_rf, "R8 resume_irq", resume_irq, m_rf);
      chk(lazy_clk == m_lz, "R10 lazy_clk", lazy_clk, m_lz);
    end
  end

  always @(negedge clk) begin
    if (tick_run) tick <= ~tick;
    else tick <= 1'b0;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    int_rd = 1'b1; cyc(1); int_rd = 1'b0;
  endtask

  task automatic enter_susp();
    go_susp = 1'b1; cyc(3); go_susp = 1'b0; cyc(2);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    summary();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    cyc(1);
    // R11 reset state at the ports
    chk(!suspend_o && !susp_irq && !resume_irq && !lazy_clk && !idle_long && reg_wr_en,
        "R11 reset state", {suspend_o, susp_irq, resume_irq, lazy_clk, idle_long}, 0);

    // R1/R2: long idle, broken once before the limit
    tick_run = 1'b1;
    line_state = 2'b01; cyc(14);
    line_state = 2'b10; cyc(2);
    chk(!idle_long, "R1 short idle", idle_long, 0);
    line_state = 2'b01; cyc(40);
    chk(idle_long && susp_irq, "R1 long idle", {idle_long, susp_irq}, 3);
    pulse_rd(); cyc(10);
    chk(!susp_irq, "R2 flag clear once", susp_irq, 0);
    line_state = 2'b00; cyc(2); line_state = 2'b01; cyc(30);
    int_rd = 1'b1; cyc(2); int_rd = 1'b0; cyc(2);

    // R3: rising edge alone does not enter
    go_susp = 1'b1; cyc(4);
    chk(!suspend_o, "R3 rise no entry", suspend_o, 0);
    go_susp = 1'b0; cyc(2);
    chk(suspend_o && !reg_wr_en, "R3/R4 entry", {suspend_o, reg_wr_en}, 2);

    // R10 slow clock, R9 unlock ignored while suspended
    lazy_en = 1'b1; cyc(20);
    unlock_cmd = 1'b1; cyc(1); unlock_cmd = 1'b0;

    // R7 gated host wake
    vbus_sense_en = 1'b1; vbus_present = 1'b0;
    line_state = 2'b10; cyc(5);
    chk(suspend_o, "R7 gated K ignored", suspend_o, 1);
    vbus_present = 1'b1; cyc(2);
    chk(!suspend_o && resume_irq, "R5/R8 wake", {suspend_o, resume_irq}, 1);
    line_state = 2'b01;
    pulse_rd(); cyc(5);
    chk(!reg_wr_en, "R9 still locked", reg_wr_en, 0);
    unlock_cmd = 1'b1; cyc(1); unlock_cmd = 1'b0; cyc(1);
    chk(reg_wr_en && fifo_wr_en, "R9 unlocked", {reg_wr_en, fifo_wr_en}, 3);

    // R6 pin wake with bus voltage absent
    enter_susp(); cyc(5);
    vbus_present = 1'b0; line_state = 2'b10; cyc(3);
    wakeup_pin = 1'b1; cyc(1); wakeup_pin = 1'b0; cyc(1);
    chk(!suspend_o, "R6 pin wake", suspend_o, 0);
    line_state = 2'b01; int_rd = 1'b1; cyc(1); int_rd = 1'b0;
    wr_req_reg = 1'b0; unlock_cmd = 1'b1; cyc(1); unlock_cmd = 1'b0; cyc(2);

    // R5 ungated host wake, with flag read in the wake cycle
    vbus_sense_en = 1'b0; wr_req_reg = 1'b1;
    enter_susp(); cyc(7);
    line_state = 2'b10; int_rd = 1'b1; cyc(1); int_rd = 1'b0;
    line_state = 2'b01; cyc(2);
    chk(resume_irq, "R8 set beats clear", resume_irq, 1);
    // unlock in same cycle as entry: entry wins
    unlock_cmd = 1'b1; go_susp = 1'b1; cyc(1); go_susp = 1'b0; cyc(1);
    unlock_cmd = 1'b0; cyc(4);
    chk(suspend_o && !reg_wr_en, "R9 entry beats unlock", {suspend_o, reg_wr_en}, 2);
    wakeup_pin = 1'b1; cyc(1); wakeup_pin = 1'b0; cyc(10);

    tick_run = 1'b0;
    cyc(4);
    summary();
  end
endmodule